// File: doc/BRIEF.md
# Base Address Window Decoder

This block sits on the target side of a shared parallel bus. It holds two base address registers, one for an I/O window and one for a memory window, and a small command register with one decode-enable bit for each space. Configuration software reaches all three through a register index with read and write strobes. It finds each window's size by writing all ones and reading the value back, then writes a base address into each register.

During normal operation the block compares every bus address, qualified by an I/O-or-memory space select, against both windows. It raises one hit output for the window that matches. The low four bits of each base register are fixed type bits. A register whose writable address field is zero counts as unallocated, and it decodes nothing even though its type bits still read back.

Window sizes are parameters: 256 bytes for I/O and 4 KiB for memory by default.

Top module: `awd_top`

## Requirements
- R1: After reset the command register (index 0) reads 0x00000000, the I/O base (index 1) reads 0x00000001, the memory base (index 2) reads 0x00000000, and neither hit output is high.
- R2: The I/O base always reads bit 0 as one and bits 7:1 as zero, whatever is written.
- R3: The memory base always reads bits 11:0 as zero, whatever is written.
- R4: Writing 0xFFFFFFFF reads back as 0xFFFFFF01 for the I/O base and as 0xFFFFF000 for the memory base, which shows the window size.
- R5: Reads of indices 3 to 7 return zero, and writes to those indices leave all three registers unchanged.
- R6: A base register whose address field (bits 31:8 for I/O, bits 31:12 for memory) is zero never raises its hit, even with decode enabled and a bus address of zero in those bits.
- R7: hit_io is high when bus_is_io is 1, command bit 0 is set, and bus_addr[31:8] equals the nonzero I/O address field. It is low for any address outside that 256-byte window.
- R8: hit_mem is high when bus_is_io is 0, command bit 1 is set, and bus_addr[31:12] equals the nonzero memory address field. It is low for any address outside that 4 KiB window.
- R9: Command bit 0 enables I/O decode and bit 1 enables memory decode. Only those two bits are writable, and all other command bits read zero.
- R10: A hit is given only for the space that bus_is_io selects, so at most one hit output is high at a time.
- R11: A configuration write takes effect at the clock edge that samples it. Hit outputs and read data show the old value before that edge and the new value after it.
- R12: cfg_rdata is zero whenever cfg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational |
| bus_addr | input | 32 | Bus address to decode |
| bus_is_io | input | 1 | 1 selects the I/O space, 0 selects the memory space |
| hit_io | output | 1 | Bus address falls in the I/O window |
| hit_mem | output | 1 | Bus address falls in the memory window |

## Verification
The block's only state is two address fields and two enable bits, and both read data and hit outputs depend combinationally on that state. A corrupted field or enable therefore shows up in the same cycle as a wrong read-back value or as a missing or spurious hit. A write landing in the wrong register shows at once as a changed read-back of an untouched index. A register that ignores the zero-field rule shows as a hit for an address whose upper bits are all zero.

// File: rtl/awd_pkg.sv
package awd_pkg;
   localparam int unsigned CFG_IDX_W = 3;
   localparam int unsigned CFG_DW    = 32;
   localparam int unsigned TYPE_W    = 4;

   localparam logic [CFG_IDX_W-1:0] IDX_CMD = 3'd0;
   localparam logic [CFG_IDX_W-1:0] IDX_IO  = 3'd1;
   localparam logic [CFG_IDX_W-1:0] IDX_MEM = 3'd2;

   localparam logic [TYPE_W-1:0] TYPE_IO  = 4'b0001;
   localparam logic [TYPE_W-1:0] TYPE_MEM = 4'b0000;

   localparam int unsigned EN_IO_BIT  = 0;
   localparam int unsigned EN_MEM_BIT = 1;

   typedef struct packed {
      logic                 wr;
      logic [CFG_IDX_W-1:0] idx;
      logic [CFG_DW-1:0]    wdata;
   } cfg_req_t;
endpackage

// File: rtl/awd_cmd_reg.sv
module awd_cmd_reg
   import awd_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_value,
   output logic          en_io,
   output logic          en_mem
);
   localparam int unsigned EN_W = 2;

   if (DW < EN_W) begin : g_bad_width
      $error("awd_cmd_reg: DW too small");
   end

   logic [EN_W-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en) begin
         en_q <= wdata[EN_W-1:0];
      end
   end

   assign rd_value = {{(DW-EN_W){1'b0}}, en_q};
   assign en_io    = en_q[EN_IO_BIT];
   assign en_mem   = en_q[EN_MEM_BIT];
endmodule

// File: rtl/awd_base_reg.sv
module awd_base_reg
   import awd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned SIZE_LOG2 = 8,
   parameter bit          IS_IO     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] rd_value,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              space_ok,
   output logic              hit
);
   localparam int unsigned FIELD_W = ADDR_W - SIZE_LOG2;
   localparam int unsigned GAP_W   = SIZE_LOG2 - TYPE_W;

   if (SIZE_LOG2 < TYPE_W || SIZE_LOG2 >= ADDR_W) begin : g_bad_size
      $error("awd_base_reg: SIZE_LOG2 out of range");
   end

   logic [FIELD_W-1:0] field_q;
   logic [TYPE_W-1:0]  type_bits;
   logic               field_set;

   if (IS_IO) begin : g_io_type
      assign type_bits = TYPE_IO;
   end else begin : g_mem_type
      assign type_bits = TYPE_MEM;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q <= '0;
      end else if (wr_en) begin
         field_q <= wdata[ADDR_W-1:SIZE_LOG2];
      end
   end

   if (GAP_W > 0) begin : g_gap
      assign rd_value = {field_q, {GAP_W{1'b0}}, type_bits};
   end else begin : g_no_gap
      assign rd_value = {field_q, type_bits};
   end

   assign field_set = |field_q;
   assign hit = space_ok && field_set && (bus_addr[ADDR_W-1:SIZE_LOG2] == field_q);
endmodule

// File: rtl/awd_top.sv
module awd_top
   import awd_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned IO_SIZE_LOG2  = 8,
   parameter int unsigned MEM_SIZE_LOG2 = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic                 cfg_rd,
   input  logic [CFG_IDX_W-1:0] cfg_idx,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   output logic [ADDR_W-1:0]    cfg_rdata,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_is_io,
   output logic                 hit_io,
   output logic                 hit_mem
);
   if (ADDR_W != CFG_DW) begin : g_bad_aw
      $error("awd_top: ADDR_W must equal the configuration data width");
   end

   cfg_req_t          req;
   logic [ADDR_W-1:0] cmd_rd, io_rd, mem_rd;
   logic              en_io, en_mem;
   logic              wr_cmd, wr_io, wr_mem;

   assign req = '{wr: cfg_wr, idx: cfg_idx, wdata: cfg_wdata};

   assign wr_cmd = req.wr && (req.idx == IDX_CMD);
   assign wr_io  = req.wr && (req.idx == IDX_IO);
   assign wr_mem = req.wr && (req.idx == IDX_MEM);

   awd_cmd_reg #(.DW(ADDR_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_cmd),
      .wdata    (req.wdata),
      .rd_value (cmd_rd),
      .en_io    (en_io),
      .en_mem   (en_mem)
   );

   awd_base_reg #(.ADDR_W(ADDR_W), .SIZE_LOG2(IO_SIZE_LOG2), .IS_IO(1'b1)) u_io (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_io),
      .wdata    (req.wdata),
      .rd_value (io_rd),
      .bus_addr (bus_addr),
      .space_ok (bus_is_io && en_io),
      .hit      (hit_io)
   );

   awd_base_reg #(.ADDR_W(ADDR_W), .SIZE_LOG2(MEM_SIZE_LOG2), .IS_IO(1'b0)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_mem),
      .wdata    (req.wdata),
      .rd_value (mem_rd),
      .bus_addr (bus_addr),
      .space_ok (!bus_is_io && en_mem),
      .hit      (hit_mem)
   );

   always_comb begin
      cfg_rdata = '0;
      if (cfg_rd) begin
         case (cfg_idx)
            IDX_CMD: cfg_rdata = cmd_rd;
            IDX_IO:  cfg_rdata = io_rd;
            IDX_MEM: cfg_rdata = mem_rd;
            default: cfg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned IO_SZ    = 8,
   parameter int unsigned MEM_SZ   = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic              cfg_rd,
   input logic [2:0]        cfg_idx,
   input logic [ADDR_W-1:0] cfg_rdata,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_is_io,
   input logic              hit_io,
   input logic              hit_mem
);
   assert_io_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_idx == 3'd1) |-> (cfg_rdata[IO_SZ-1:0] == {{(IO_SZ-1){1'b0}}, 1'b1}));

   assert_mem_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_idx == 3'd2) |-> (cfg_rdata[MEM_SZ-1:0] == '0));

   assert_unused_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_idx > 3'd2) |-> (cfg_rdata == '0));

   assert_zero_field_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_io |-> (bus_addr[ADDR_W-1:IO_SZ] != '0));

   assert_zero_field_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_mem |-> (bus_addr[ADDR_W-1:MEM_SZ] != '0));

   assert_cmd_high_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd && cfg_idx == 3'd0) |-> (cfg_rdata[ADDR_W-1:2] == '0));

   assert_space_io_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_io |-> bus_is_io);

   assert_space_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_mem |-> !bus_is_io);

   assert_hit_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cfg_wr) && $stable(bus_addr) && $stable(bus_is_io))
         |-> ($stable(hit_io) && $stable(hit_mem)));

   assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd |-> (cfg_rdata == '0));
endmodule

bind awd_top awd_checker #(
   .ADDR_W (ADDR_W),
   .IO_SZ  (IO_SIZE_LOG2),
   .MEM_SZ (MEM_SIZE_LOG2)
) u_awd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_rd    (cfg_rd),
   .cfg_idx   (cfg_idx),
   .cfg_rdata (cfg_rdata),
   .bus_addr  (bus_addr),
   .bus_is_io (bus_is_io),
   .hit_io    (hit_io),
   .hit_mem   (hit_mem)
);

// File: tb/test_awd_top.sv
`timescale 1ns/1ps
module test_awd_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_rd = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] bus_addr = '0;
   logic        bus_is_io = 1'b0;
   logic        hit_io, hit_mem;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   awd_top i_awd_top (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .bus_addr(bus_addr), .bus_is_io(bus_is_io),
      .hit_io(hit_io), .hit_mem(hit_mem)
   );

   typedef struct packed {
      logic        wr;
      logic [2:0]  idx;
      logic [31:0] dat;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'd0, 32'h0,          32'h00000000, 8'd1},  // R1
      '{1'b0, 3'd1, 32'h0,          32'h00000001, 8'd1},  // R1
      '{1'b0, 3'd2, 32'h0,          32'h00000000, 8'd1},  // R1
      '{1'b1, 3'd1, 32'hFFFFFFFF,   32'h0,        8'd4},  // R4 probe
      '{1'b0, 3'd1, 32'h0,          32'hFFFFFF01, 8'd4},  // R4
      '{1'b1, 3'd2, 32'hFFFFFFFF,   32'h0,        8'd4},
      '{1'b0, 3'd2, 32'h0,          32'hFFFFF000, 8'd4},  // R4
      '{1'b1, 3'd1, 32'h000012FE,   32'h0,        8'd2},
      '{1'b0, 3'd1, 32'h0,          32'h00001201, 8'd2},  // R2
      '{1'b1, 3'd2, 32'hABCD5FFF,   32'h0,        8'd3},
      '{1'b0, 3'd2, 32'h0,          32'hABCD5000, 8'd3},  // R3
      '{1'b1, 3'd0, 32'hFFFFFFFF,   32'h0,        8'd9},
      '{1'b0, 3'd0, 32'h0,          32'h00000003, 8'd9},  // R9
      '{1'b1, 3'd5, 32'hFFFFFFFF,   32'h0,        8'd5},
      '{1'b0, 3'd5, 32'h0,          32'h00000000, 8'd5},  // R5
      '{1'b0, 3'd1, 32'h0,          32'h00001201, 8'd5},  // R5 untouched
      '{1'b0, 3'd2, 32'h0,          32'hABCD5000, 8'd5}   // R5 untouched
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] idx, input logic [31:0] dat);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = dat;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input string tag, input logic [2:0] idx, input logic [31:0] exp);
      cfg_rd = 1'b1; cfg_idx = idx;
      #2;
      check(tag, cfg_rdata, exp);
      cfg_rd = 1'b0;
      #1;
   endtask

   task automatic bus_chk(input string tag, input logic [31:0] a, input logic io,
                          input logic e_io, input logic e_mem);
      bus_addr = a; bus_is_io = io;
      #2;
      check(tag, {30'd0, hit_io, hit_mem}, {30'd0, e_io, e_mem});
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_chk("R1 no hit after reset", 32'h0, 1'b1, 1'b0, 1'b0);
      bus_chk("R1 no hit after reset mem", 32'h0, 1'b0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) begin
            cfg_write(VECS[i].idx, VECS[i].dat);
         end else begin
            @(negedge clk);
            cfg_read($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].idx, VECS[i].exp);
         end
      end

      // I/O base 0x1200, memory base 0xABCD5000, both enabled
      @(negedge clk);
      bus_chk("R7 io hit",            32'h00001234, 1'b1, 1'b1, 1'b0);
      bus_chk("R7 io top of window",  32'h000012FF, 1'b1, 1'b1, 1'b0);
      bus_chk("R7 io outside",        32'h00001300, 1'b1, 1'b0, 1'b0);
      bus_chk("R10 io addr mem space",32'h00001234, 1'b0, 1'b0, 1'b0);
      bus_chk("R8 mem hit",           32'hABCD5FFC, 1'b0, 1'b0, 1'b1);
      bus_chk("R8 mem outside",       32'hABCD6000, 1'b0, 1'b0, 1'b0);
      bus_chk("R10 mem addr io space",32'hABCD5000, 1'b1, 1'b0, 1'b0);

      cfg_write(3'd0, 32'h00000002);
      bus_chk("R9 io disabled",       32'h00001234, 1'b1, 1'b0, 1'b0);
      bus_chk("R9 mem still enabled", 32'hABCD5000, 1'b0, 1'b0, 1'b1);
      cfg_write(3'd0, 32'h00000001);
      bus_chk("R9 mem disabled",      32'hABCD5000, 1'b0, 1'b0, 1'b0);
      cfg_write(3'd0, 32'h00000003);

      // R11: timing of a base change
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = 3'd1; cfg_wdata = 32'h00005600;
      bus_chk("R11 old base before edge", 32'h00001234, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      cfg_wr = 1'b0;
      bus_chk("R11 old base gone",  32'h00001234, 1'b1, 1'b0, 1'b0);
      bus_chk("R11 new base hits",  32'h00005610, 1'b1, 1'b1, 1'b0);

      // R6: zero address field disables decode
      cfg_write(3'd1, 32'h000000FF);
      bus_chk("R6 io zero field",   32'h00000010, 1'b1, 1'b0, 1'b0);
      cfg_read("R6 io reads type only", 3'd1, 32'h00000001);
      cfg_write(3'd2, 32'h00000FFF);
      bus_chk("R6 mem zero field",  32'h00000100, 1'b0, 1'b0, 1'b0);
      cfg_read("R6 mem reads zero", 3'd2, 32'h00000000);

      // R12
      cfg_write(3'd2, 32'h80000000);
      cfg_rd = 1'b0; cfg_idx = 3'd2;
      #2;
      check("R12 idle rdata", cfg_rdata, 32'h0);

      // R1: reset again mid-run
      bus_addr = 32'h80000000; bus_is_io = 1'b0;
      #2;
      check("R1 pre-reset mem hit", {31'd0, hit_mem}, 32'd1);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      bus_chk("R1 hits cleared", 32'h80000000, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cfg_read("R1 cmd after reset", 3'd0, 32'h00000000);
      cfg_read("R1 io after reset",  3'd1, 32'h00000001);
      cfg_read("R1 mem after reset", 3'd2, 32'h00000000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule